// File: doc/BRIEF.md
# Pin Controller with Edge Events and Interrupt

This block provides a bank of general-purpose pins behind a small word-wide register bus. Software sets each pin as an output, which is driven from a stored data bit, or as an input, which is sampled through a synchroniser into that same data word. Pins are numbered from the most significant end: pin n lives in register bit (NPINS-1-n).

Input pins record events in a sticky event word. A per-pin control bit selects the event kind: any change of level, or only a high-to-low change. Software clears events by writing ones to the event word. Writing zero to a bit leaves that bit alone. One level interrupt line is high while any event bit is also enabled in the mask word. An open-drain select word is kept as plain storage. Only full-word accesses take effect. Reads return data one clock after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: Full-word writes to byte offsets 0x00 (direction), 0x04 (open-drain select), 0x10 (mask) and 0x14 (event kind) store the written value, and reads at those offsets return it. Offset 0x08 reads the data word and offset 0x0C reads the event word.
- R3: A byte offset outside those six reads as zero, and a write to it changes no register.
- R4: A write with `bus_full` low changes nothing, and a read with `bus_full` low returns zero.
- R5: Pin n maps to register bit (NPINS-1-n). A direction bit of 1 sets `pin_oe[n]` and drives `pin_out[n]` from data bit (NPINS-1-n).
- R6: For input pins, the data bit reads back the pin level once the level has been stable for three clocks. Writes to the data word change only the bits of output pins.
- R7: Writing the event word clears each bit written as 1 and keeps each bit written as 0.
- R8: An input pin whose event-kind bit is 0 sets its event bit on every level change. Output pins never set event bits.
- R9: An input pin whose event-kind bit is 1 sets its event bit only on a 1-to-0 change.
- R10: `irq` is a register that equals the OR of (event AND mask) in every cycle after reset. It therefore follows a register write or an event one clock after it happens.
- R11: When an event is set for a bit in the same clock that software writes a 1 to clear it, the bit ends up set.
- R12: Read data appears on `bus_rdata` in the clock after `bus_rd` is sampled, and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_full | input | 1 | High when the access is full-word |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pin levels, may be asynchronous |
| pin_out | output | NPINS | Driven pin values |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that reset is held from the first clock. They also assume one bus access per cycle, so a narrow access is never paired with a full-word write to the same register, and that `bus_wr` and `bus_rd` are never asserted together. Pin inputs may change at any time. The bench drives every input at the falling edge and issues one access at a time. It holds pins steady for several clocks around each change, so the expected event word follows from one level change per pin. The set-versus-clear race is driven on purpose, at the exact clock computed from the two synchroniser stages.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [31:0] OFF_DIR = 32'h00;
  localparam logic [31:0] OFF_ODS = 32'h04;
  localparam logic [31:0] OFF_DAT = 32'h08;
  localparam logic [31:0] OFF_EVT = 32'h0C;
  localparam logic [31:0] OFF_MSK = 32'h10;
  localparam logic [31:0] OFF_KND = 32'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_ODS,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_KND,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [31:0] off);
    case (off)
      OFF_DIR: return SEL_DIR;
      OFF_ODS: return SEL_ODS;
      OFF_DAT: return SEL_DAT;
      OFF_EVT: return SEL_EVT;
      OFF_MSK: return SEL_MSK;
      OFF_KND: return SEL_KND;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Per-pin synchroniser chain plus one history flop for edge detection.
// Outputs are already in register bit order (pin n -> bit NPINS-1-n).
module gpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] prev_o
);

  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int BIT = NPINS - 1 - p;
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        hist_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_in[p]};
        hist_q  <= chain_q[LAST];
      end
    end

    assign lvl_o[BIT]  = chain_q[LAST];
    assign prev_o[BIT] = hist_q;
  end

endmodule

// File: rtl/gpio_bus_regs.sv
// Register decode, configuration storage, data word and registered read port.
module gpio_bus_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_full,
  input  logic              bus_rd,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic [NPINS-1:0]  lvl_i,
  input  logic [NPINS-1:0]  ev_i,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dat_q,
  output logic [NPINS-1:0]  msk_q,
  output logic [NPINS-1:0]  knd_q,
  output logic [NPINS-1:0]  msk_d,
  output logic [NPINS-1:0]  clr_vec,
  output logic [NPINS-1:0]  rdata_q
);

  reg_sel_e         sel;
  logic             wr_ok;
  logic [NPINS-1:0] ods_q;
  logic [NPINS-1:0] dir_d, ods_d, knd_d, dat_d;
  logic [NPINS-1:0] rd_mux;

  assign sel   = decode_off(32'(bus_addr));
  assign wr_ok = bus_wr && bus_full;

  always_comb begin
    dir_d   = dir_q;
    ods_d   = ods_q;
    msk_d   = msk_q;
    knd_d   = knd_q;
    clr_vec = '0;
    if (wr_ok) begin
      case (sel)
        SEL_DIR: dir_d   = bus_wdata;
        SEL_ODS: ods_d   = bus_wdata;
        SEL_MSK: msk_d   = bus_wdata;
        SEL_KND: knd_d   = bus_wdata;
        SEL_EVT: clr_vec = bus_wdata;
        default: ;
      endcase
    end
  end

  // Output bits take written data, input bits track the synchronised level.
  always_comb begin
    dat_d = dat_q;
    if (wr_ok && sel == SEL_DAT) dat_d = bus_wdata;
    dat_d = (dat_d & dir_q) | (lvl_i & ~dir_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      ods_q <= '0;
      msk_q <= '0;
      knd_q <= '0;
      dat_q <= '0;
    end else begin
      dir_q <= dir_d;
      ods_q <= ods_d;
      msk_q <= msk_d;
      knd_q <= knd_d;
      dat_q <= dat_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_DIR: rd_mux = dir_q;
      SEL_ODS: rd_mux = ods_q;
      SEL_DAT: rd_mux = dat_q;
      SEL_EVT: rd_mux = ev_i;
      SEL_MSK: rd_mux = msk_q;
      SEL_KND: rd_mux = knd_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= bus_full ? rd_mux : '0;
  end

endmodule

// File: rtl/gpio_evt_unit.sv
// Sticky event word with write-one-to-clear (set wins) and registered interrupt.
module gpio_evt_unit #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] knd_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] msk_d_i,
  output logic [NPINS-1:0] ev_q,
  output logic             irq_q
);

  logic [NPINS-1:0] change, fall, set_vec, ev_d;

  assign change  = lvl_i ^ prev_i;
  assign fall    = prev_i & ~lvl_i;
  assign set_vec = change & ~dir_i & (~knd_i | fall);
  assign ev_d    = (ev_q & ~clr_i) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      ev_q  <= ev_d;
      irq_q <= |(ev_d & msk_d_i);
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_full,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NPINS-1:0] lvl, prev;
  logic [NPINS-1:0] dir_q, dat_q, msk_q, knd_q, msk_d, clr_vec, ev_q;

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  gpio_bus_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_full  (bus_full),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .lvl_i     (lvl),
    .ev_i      (ev_q),
    .dir_q     (dir_q),
    .dat_q     (dat_q),
    .msk_q     (msk_q),
    .knd_q     (knd_q),
    .msk_d     (msk_d),
    .clr_vec   (clr_vec),
    .rdata_q   (bus_rdata)
  );

  gpio_evt_unit #(.NPINS(NPINS)) evt_i (
    .clk     (clk),
    .rst     (rst),
    .lvl_i   (lvl),
    .prev_i  (prev),
    .dir_i   (dir_q),
    .knd_i   (knd_q),
    .clr_i   (clr_vec),
    .msk_d_i (msk_d),
    .ev_q    (ev_q),
    .irq_q   (irq)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_drive
    assign pin_out[p] = dat_q[NPINS-1-p];
    assign pin_oe[p]  = dir_q[NPINS-1-p];
  end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic              bus_full,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  ev_q,
  input logic [NPINS-1:0]  msk_q
);

  logic [NPINS-1:0] oe_bits;
  logic             evt_wr, dir_wr;

  for (genvar p = 0; p < NPINS; p++) begin : g_rev
    assign oe_bits[NPINS-1-p] = pin_oe[p];
  end

  assign evt_wr = bus_wr && bus_full && (bus_addr == ADDR_W'(OFF_EVT));
  assign dir_wr = bus_wr && bus_full && (bus_addr == ADDR_W'(OFF_DIR));

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && irq == 1'b0 && bus_rdata == '0));

  p_narrow_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_full) |=> ($stable(pin_oe) && $stable(msk_q)));

  p_narrow_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_full) |=> bus_rdata == '0);

  p_dir_drive_r5: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> oe_bits == $past(bus_wdata));

  p_w1c_only_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (|($past(ev_q) & ~ev_q & ~($past(evt_wr) ? $past(bus_wdata) : '0))) == 1'b0);

  p_inputs_only_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (|(ev_q & ~$past(ev_q) & $past(oe_bits))) == 1'b0);

  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(ev_q & msk_q));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_full  (bus_full),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .ev_q      (ev_q),
  .msk_q     (msk_q)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int AW = 12;

  localparam logic [AW-1:0] A_DIR = 12'h000;
  localparam logic [AW-1:0] A_ODS = 12'h004;
  localparam logic [AW-1:0] A_DAT = 12'h008;
  localparam logic [AW-1:0] A_EVT = 12'h00C;
  localparam logic [AW-1:0] A_MSK = 12'h010;
  localparam logic [AW-1:0] A_KND = 12'h014;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [NP-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic          bus_full = 1'b1;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the register contents
  logic [NP-1:0] m_dir, m_ods, m_dat, m_ev, m_msk, m_knd;

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_full(bus_full),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NP-1:0] rev(input logic [NP-1:0] v);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[NP-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_reg(input logic [AW-1:0] a);
    case (a)
      A_DIR: return m_dir;
      A_ODS: return m_ods;
      A_DAT: return m_dat;
      A_EVT: return m_ev;
      A_MSK: return m_msk;
      A_KND: return m_knd;
      default: return '0;
    endcase
  endfunction

  // events expected from one pin change, in register bit order
  function automatic logic [NP-1:0] exp_set(input logic [NP-1:0] oldp,
                                            input logic [NP-1:0] newp);
    logic [NP-1:0] o, n, s;
    o = rev(oldp);
    n = rev(newp);
    s = (o ^ n) & ~m_dir & (~m_knd | (o & ~n));
    return s;
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [NP-1:0] d, input logic full);
    bus_addr = a; bus_wdata = d; bus_full = full; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_full = 1'b1;
  endtask

  // R12: data is sampled at the falling edge right after the capturing edge
  task automatic bus_read(input logic [AW-1:0] a, input logic full, output logic [NP-1:0] d);
    bus_addr = a; bus_full = full; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0; bus_full = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    m_dat = (m_dat & m_dir) | (rev(pin_in) & ~m_dir);
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [NP-1:0] d);
    case (a)
      A_DIR: m_dir = d;
      A_ODS: m_ods = d;
      A_DAT: m_dat = (d & m_dir) | (m_dat & ~m_dir);
      A_EVT: m_ev  = m_ev & ~d;
      A_MSK: m_msk = d;
      A_KND: m_knd = d;
      default: ;
    endcase
  endtask

  task automatic full_write(input logic [AW-1:0] a, input logic [NP-1:0] d);
    bus_write(a, d, 1'b1);
    model_write(a, d);
  endtask

  task automatic change_pins(input logic [NP-1:0] np);
    m_ev = m_ev | exp_set(pin_in, np);
    pin_in = np;
  endtask

  task automatic check_all(input string tag);
    logic [NP-1:0] rd;
    bus_read(A_DIR, 1'b1, rd); chk({tag, " R2 dir"}, rd, m_dir);
    bus_read(A_ODS, 1'b1, rd); chk({tag, " R2 ods"}, rd, m_ods);
    bus_read(A_DAT, 1'b1, rd); chk({tag, " R6 data"}, rd, m_dat);
    bus_read(A_EVT, 1'b1, rd); chk({tag, " R8/R9 events"}, rd, m_ev);
    bus_read(A_MSK, 1'b1, rd); chk({tag, " R2 mask"}, rd, m_msk);
    bus_read(A_KND, 1'b1, rd); chk({tag, " R2 kind"}, rd, m_knd);
    chk({tag, " R5 pin_oe"}, pin_oe, rev(m_dir));
    chk({tag, " R5 pin_out"}, pin_out, rev(m_dat));
    chk({tag, " R10 irq"}, {31'b0, irq}, {31'b0, |(m_ev & m_msk)});
  endtask

  task automatic do_reset();
    pin_in = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_dir = '0; m_ods = '0; m_dat = '0; m_ev = '0; m_msk = '0; m_knd = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] rd;
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    do_reset();

    // R1 reset state
    check_all("R1 reset");

    // R2 readback of plain registers
    full_write(A_ODS, 32'hA5A5_0F0F);
    full_write(A_MSK, 32'h0000_FFFF);
    full_write(A_KND, 32'h1234_5678);
    check_all("R2 readback");

    // R3 unmapped offsets
    bus_write(12'h018, 32'hFFFF_FFFF, 1'b1);
    bus_write(12'h002, 32'hFFFF_FFFF, 1'b1);
    bus_write(12'hFFC, 32'hFFFF_FFFF, 1'b1);
    bus_read(12'h018, 1'b1, rd); chk("R3 unmapped read 0x18", rd, '0);
    bus_read(12'h002, 1'b1, rd); chk("R3 unmapped read 0x02", rd, '0);
    check_all("R3 after unmapped writes");

    // R4 narrow access
    bus_write(A_MSK, 32'hFFFF_0000, 1'b0);
    bus_write(A_DIR, 32'hFFFF_FFFF, 1'b0);
    bus_read(A_ODS, 1'b0, rd); chk("R4 narrow read", rd, '0);
    check_all("R4 after narrow writes");

    // R5 pin 0 is the top bit; R12 read latency
    full_write(A_DIR, 32'h8000_0001);
    full_write(A_DAT, 32'h8000_0000);
    chk("R5 pin0 oe", {31'b0, pin_oe[0]}, 32'd1);
    chk("R5 pin0 out", {31'b0, pin_out[0]}, 32'd1);
    chk("R5 pin31 out", {31'b0, pin_out[31]}, 32'd0);
    bus_read(A_DIR, 1'b1, rd); chk("R12 one-clock read", rd, 32'h8000_0001);
    settle();
    check_all("R5 mapping");

    // R6 input sampling, data write ignored on inputs
    full_write(A_DIR, 32'h0000_0000);
    full_write(A_KND, 32'h0000_0000);
    full_write(A_MSK, 32'h0000_0000);
    change_pins(32'h0000_0003);
    settle();
    full_write(A_DAT, 32'h0000_0000);
    settle();
    check_all("R6 inputs");

    // R7 write-one-to-clear: clear only bit 31 (pin 0)
    full_write(A_EVT, 32'h8000_0000);
    settle();
    check_all("R7 partial clear");
    full_write(A_EVT, 32'hFFFF_FFFF);
    settle();
    check_all("R7 full clear");

    // R9 falling-only on pin 3 (bit 28)
    full_write(A_KND, 32'h1000_0000);
    change_pins(pin_in | 32'h0000_0008);
    settle();
    bus_read(A_EVT, 1'b1, rd); chk("R9 rise ignored", rd & 32'h1000_0000, '0);
    change_pins(pin_in & ~32'h0000_0008);
    settle();
    bus_read(A_EVT, 1'b1, rd); chk("R9 fall sets", rd & 32'h1000_0000, 32'h1000_0000);
    full_write(A_MSK, 32'h1000_0000);
    chk("R10 irq after mask write", {31'b0, irq}, 32'd1);
    full_write(A_EVT, 32'h1000_0000);
    chk("R10 irq after clear", {31'b0, irq}, 32'd0);
    check_all("R9 done");

    // R11 set and clear on the same bit (pin 5 -> bit 26)
    full_write(A_KND, 32'h0000_0000);
    pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_write(A_EVT, 32'h0400_0000, 1'b1);
    bus_read(A_EVT, 1'b1, rd); chk("R11 set wins", rd & 32'h0400_0000, 32'h0400_0000);
    full_write(A_EVT, 32'hFFFF_FFFF);
    m_ev = '0;
    settle();
    check_all("R11 cleanup");

    // constrained random phase
    do_reset();
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [NP-1:0] v;
      op = int'($urandom_range(0, 9));
      v  = $urandom();
      case (op)
        0: full_write(A_DIR, v);
        1: full_write(A_ODS, v);
        2: full_write(A_DAT, v);
        3: full_write(A_EVT, v);
        4: full_write(A_MSK, v);
        5: full_write(A_KND, v);
        6, 7: change_pins(pin_in ^ (v & $urandom()));
        8: bus_write(A_MSK + AW'(4 * int'($urandom_range(0, 1))) - AW'(16 * int'($urandom_range(0, 1))),
                     v, 1'b0);
        default: bus_write(12'h020 + AW'(4 * int'($urandom_range(0, 8))), v, 1'b1);
      endcase
      settle();
      if (it % 10 == 9) check_all("random");
      else chk("R10 random irq", {31'b0, irq}, {31'b0, |(m_ev & m_msk)});
    end
    check_all("random end");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule